// File: doc/BRIEF.md
# Dual-Route ADC Clock Prescaler

This block produces the conversion clock for an analog-to-digital converter. It has two routes. On the kernel route, a fast kernel clock (up to 170 MHz, not phase-related to the bus clock) is divided by one of twelve ratios. These ratios mix powers of two with the even values 6, 10 and 12. On the bus route, the bus clock is divided by 1, 2 or 4. A two-bit route field picks the route. A value of zero selects the kernel route, and the other values select the bus route and its divisor.

Each route has its own free-running divider, clocked by its own source. The two divided clocks are combined by a glitch-free gated multiplexer. Each side's enable changes only while that side's output is low, and only after the other side's enable has been seen off through a two-flop synchronizer. A new ratio is loaded only at a period boundary of the divided clock, so a partial period is never emitted. When the bus route is asked to divide by 1 while the bus prescaler is not at 1, the block raises a configuration-error flag.

Top module: `adc_clk_prescaler`

## Requirements
- R1: While both resets are asserted, adc_clk_o and cfg_err_o are both low.
- R2: With sync_mode_i = 0, the output period is the kernel period times the ratio picked by ratio_code_i. Codes 0 to 11 give, in order, 1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128, 256.
- R3: Codes 12 to 15 give divide-by-256.
- R4: For every even ratio, the high and low phases each last ratio/2 source periods (50% duty).
- R5: Code 0 on the kernel route passes the kernel clock through unchanged: high and low each last half a kernel period.
- R6: sync_mode_i = 1, 2 and 3 select the bus clock divided by 1, 2 and 4, each with 50% duty.
- R7: bus_presc_i = 0 means the bus clock is undivided, and any other value means it is divided. cfg_err_o goes high one bus-clock edge after sync_mode_i = 1 is seen with bus_presc_i != 0. In every other combination it is low one bus-clock edge later.
- R8: After a ratio change within the kernel route, every high and every low phase has either the old width or the new width. No phase is cut short.
- R9: During a route change, every high phase is a complete high phase of one of the two routes, and the two route gates are never enabled at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| kclk_i | input | 1 | Kernel clock for the kernel route |
| kclk_rst_ni | input | 1 | Active-low asynchronous reset of the kernel domain |
| bclk_i | input | 1 | Bus clock for the bus route and configuration registers |
| bclk_rst_ni | input | 1 | Active-low asynchronous reset of the bus domain |
| ratio_code_i | input | 4 | Kernel-route ratio code |
| sync_mode_i | input | 2 | 0 selects the kernel route; 1/2/3 select the bus clock divided by 1/2/4 |
| bus_presc_i | input | 4 | Current bus prescaler setting; 0 means undivided |
| adc_clk_o | output | 1 | Generated converter clock |
| adc_clk_o | output | 1 | (see above) |
| cfg_err_o | output | 1 | High when bus divide-by-1 is chosen with a divided bus clock |

## Verification
The kernel route is swept through all sixteen codes, and the high and low widths of each code are measured separately. This shows whether the code-to-ratio mapping is correct and whether the duty cycle stays at 50% for the ratios that are not powers of two. Ratio steps up, down, into pass-through and out of it confirm that every phase seen around a change is a whole old or new phase. Route swaps in both directions show that high pulses are never truncated. Four combinations of route field and bus prescaler separate the single illegal case from the legal ones.

// File: rtl/adc_clk_pkg.sv
`timescale 1ns/1ps
package adc_clk_pkg;

  localparam int RATIO_W = 9;
  localparam int CODE_W  = 4;
  localparam int PRESC_W = 4;

  typedef logic [RATIO_W-1:0] ratio_t;

  typedef enum logic [1:0] {
    ROUTE_KERNEL   = 2'd0,
    ROUTE_BUS_DIV1 = 2'd1,
    ROUTE_BUS_DIV2 = 2'd2,
    ROUTE_BUS_DIV4 = 2'd3
  } route_e;

  // Kernel-route ratio for a prescaler code; codes past the list saturate.
  function automatic ratio_t kernel_ratio(input logic [CODE_W-1:0] code);
    ratio_t r;
    case (code)
      4'd0:    r = ratio_t'(1);
      4'd1:    r = ratio_t'(2);
      4'd2:    r = ratio_t'(4);
      4'd3:    r = ratio_t'(6);
      4'd4:    r = ratio_t'(8);
      4'd5:    r = ratio_t'(10);
      4'd6:    r = ratio_t'(12);
      4'd7:    r = ratio_t'(16);
      4'd8:    r = ratio_t'(32);
      4'd9:    r = ratio_t'(64);
      4'd10:   r = ratio_t'(128);
      default: r = ratio_t'(256);
    endcase
    return r;
  endfunction

  // Bus-route ratio; the kernel selection leaves the bus divider idling at 2.
  function automatic ratio_t bus_ratio(input route_e route);
    ratio_t r;
    case (route)
      ROUTE_BUS_DIV1: r = ratio_t'(1);
      ROUTE_BUS_DIV4: r = ratio_t'(4);
      default:        r = ratio_t'(2);
    endcase
    return r;
  endfunction

  function automatic logic route_cfg_bad(input route_e route,
                                         input logic [PRESC_W-1:0] presc);
    return (route == ROUTE_BUS_DIV1) && (presc != '0);
  endfunction

endpackage

// File: rtl/adc_cfg_sync.sv
`timescale 1ns/1ps
// Moves a quasi-static multi-bit setting into another clock domain.
// The output only updates after two successive synchronized samples agree.
module adc_cfg_sync #(
  parameter int            W   = 4,
  parameter logic [W-1:0]  RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] s1_q, s2_q, s3_q, hold_q;
  logic         agree;

  assign agree = (s2_q == s3_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= RST;
      s2_q   <= RST;
      s3_q   <= RST;
      hold_q <= RST;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (agree) hold_q <= s3_q;
    end
  end

  assign q_o = hold_q;

endmodule

// File: rtl/adc_clk_div.sv
`timescale 1ns/1ps
// Free-running divider. Even ratios give 50% duty; ratio 1 bypasses.
// A new ratio is loaded only at the rising boundary of the divided clock.
module adc_clk_div #(
  parameter int RATIO_W = 9,
  localparam int CNT_W  = RATIO_W - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               clk_o,
  output logic               low_o,
  output logic               boundary_o,
  output logic               bypass_o,
  output logic               div_o,
  output logic               at_half_o,
  output logic [CNT_W-1:0]   half_o
);

  localparam logic [RATIO_W-1:0] ONE_R = RATIO_W'(1);
  localparam logic [CNT_W-1:0]   ONE_C = CNT_W'(1);

  logic             byp_q, div_q;
  logic [CNT_W-1:0] cnt_q, half_q;
  logic [CNT_W-1:0] half_next;
  logic             want_bypass, at_half, boundary;

  assign want_bypass = (ratio_i == ONE_R);
  assign half_next   = ratio_i[RATIO_W-1:1] - ONE_C;
  assign at_half     = (cnt_q == half_q);
  assign boundary    = byp_q | (~div_q & at_half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q  <= 1'b0;
      div_q  <= 1'b0;
      cnt_q  <= '0;
      half_q <= '0;
    end else if (boundary) begin
      byp_q  <= want_bypass;
      div_q  <= 1'b1;
      cnt_q  <= '0;
      half_q <= want_bypass ? '0 : half_next;
    end else if (at_half) begin
      div_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + ONE_C;
    end
  end

  assign clk_o      = byp_q ? clk_i : div_q;
  assign low_o      = byp_q | ~div_q;
  assign boundary_o = boundary;
  assign bypass_o   = byp_q;
  assign div_o      = div_q;
  assign at_half_o  = at_half;
  assign half_o     = half_q;

endmodule

// File: rtl/adc_clk_gate.sv
`timescale 1ns/1ps
// One side of the glitch-free multiplexer. The enable moves on the falling
// source edge, only while the divided clock is low, and only once the
// other side's enable is seen off.
module adc_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic peer_on_i,
  input  logic low_i,
  output logic en_o
);

  logic want_s1, want_s2, peer_s1, peer_s2, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      want_s1 <= 1'b0;
      want_s2 <= 1'b0;
      peer_s1 <= 1'b0;
      peer_s2 <= 1'b0;
    end else begin
      want_s1 <= want_i;
      want_s2 <= want_s1;
      peer_s1 <= peer_on_i;
      peer_s2 <= peer_s1;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= 1'b0;
    else if (low_i) en_q <= want_s2 & ~peer_s2;
  end

  assign en_o = en_q;

endmodule

// File: rtl/adc_clk_prescaler.sv
`timescale 1ns/1ps
module adc_clk_prescaler
  import adc_clk_pkg::*;
(
  input  logic               kclk_i,
  input  logic               kclk_rst_ni,
  input  logic               bclk_i,
  input  logic               bclk_rst_ni,
  input  logic [CODE_W-1:0]  ratio_code_i,
  input  logic [1:0]         sync_mode_i,
  input  logic [PRESC_W-1:0] bus_presc_i,
  output logic               adc_clk_o,
  output logic               cfg_err_o
);

  localparam int HALF_W = RATIO_W - 1;

  // Bus-domain configuration
  route_e mode_q;
  logic   err_q;

  always_ff @(posedge bclk_i or negedge bclk_rst_ni) begin
    if (!bclk_rst_ni) begin
      mode_q <= ROUTE_KERNEL;
      err_q  <= 1'b0;
    end else begin
      mode_q <= route_e'(sync_mode_i);
      err_q  <= route_cfg_bad(route_e'(sync_mode_i), bus_presc_i);
    end
  end

  // Kernel route
  logic [CODE_W-1:0] code_k;
  ratio_t            ratio_k;
  logic              clk_k, low_k, bnd_k, byp_k, div_k, at_half_k;
  logic [HALF_W-1:0] half_k;

  adc_cfg_sync #(.W(CODE_W), .RST('0)) u_code_sync (
    .clk_i (kclk_i),
    .rst_ni(kclk_rst_ni),
    .d_i   (ratio_code_i),
    .q_o   (code_k)
  );

  assign ratio_k = kernel_ratio(code_k);

  adc_clk_div #(.RATIO_W(RATIO_W)) u_div_k (
    .clk_i     (kclk_i),
    .rst_ni    (kclk_rst_ni),
    .ratio_i   (ratio_k),
    .clk_o     (clk_k),
    .low_o     (low_k),
    .boundary_o(bnd_k),
    .bypass_o  (byp_k),
    .div_o     (div_k),
    .at_half_o (at_half_k),
    .half_o    (half_k)
  );

  // Bus route
  ratio_t            ratio_b;
  logic              clk_b, low_b, bnd_b, byp_b, div_b, at_half_b;
  logic [HALF_W-1:0] half_b;

  assign ratio_b = bus_ratio(mode_q);

  adc_clk_div #(.RATIO_W(RATIO_W)) u_div_b (
    .clk_i     (bclk_i),
    .rst_ni    (bclk_rst_ni),
    .ratio_i   (ratio_b),
    .clk_o     (clk_b),
    .low_o     (low_b),
    .boundary_o(bnd_b),
    .bypass_o  (byp_b),
    .div_o     (div_b),
    .at_half_o (at_half_b),
    .half_o    (half_b)
  );

  // Glitch-free route multiplexer
  logic want_k, want_b, en_k, en_b;

  assign want_k = (mode_q == ROUTE_KERNEL);
  assign want_b = ~want_k;

  adc_clk_gate u_gate_k (
    .clk_i    (kclk_i),
    .rst_ni   (kclk_rst_ni),
    .want_i   (want_k),
    .peer_on_i(en_b),
    .low_i    (low_k),
    .en_o     (en_k)
  );

  adc_clk_gate u_gate_b (
    .clk_i    (bclk_i),
    .rst_ni   (bclk_rst_ni),
    .want_i   (want_b),
    .peer_on_i(en_k),
    .low_i    (low_b),
    .en_o     (en_b)
  );

  assign adc_clk_o = (clk_k & en_k) | (clk_b & en_b);
  assign cfg_err_o = err_q;

endmodule

// File: rtl/adc_clk_prescaler_chk.sv
`timescale 1ns/1ps
module adc_clk_prescaler_chk #(
  parameter int HALF_W = 8
) (
  input logic              kclk_i,
  input logic              kclk_rst_ni,
  input logic              bclk_i,
  input logic              bclk_rst_ni,
  input logic [1:0]        sync_mode_i,
  input logic [3:0]        bus_presc_i,
  input logic              cfg_err_o,
  input logic              en_k,
  input logic              en_b,
  input logic              bnd_k,
  input logic              byp_k,
  input logic              div_k,
  input logic              at_half_k,
  input logic [HALF_W-1:0] half_k,
  input logic              bnd_b,
  input logic              byp_b,
  input logic [HALF_W-1:0] half_b
);

  // R9: never both route gates open
  a_r9_gates_exclusive: assert property (@(posedge kclk_i)
    disable iff (!kclk_rst_ni || !bclk_rst_ni) !(en_k && en_b));

  // R8: kernel ratio only reloads at a boundary
  a_r8_kernel_hold: assert property (@(posedge kclk_i)
    disable iff (!kclk_rst_ni) !bnd_k |=> ($stable(half_k) && $stable(byp_k)));

  // R8: bus ratio only reloads at a boundary
  a_r8_bus_hold: assert property (@(posedge bclk_i)
    disable iff (!bclk_rst_ni) !bnd_b |=> ($stable(half_b) && $stable(byp_b)));

  // R4: a divided high phase holds until the half count is reached
  a_r4_high_held: assert property (@(posedge kclk_i)
    disable iff (!kclk_rst_ni) (!byp_k && div_k && !at_half_k) |=> div_k);

  // R7: illegal undivided bus route raises the flag
  a_r7_err_set: assert property (@(posedge bclk_i)
    disable iff (!bclk_rst_ni) (sync_mode_i == 2'd1 && bus_presc_i != 4'd0) |=> cfg_err_o);

  // R7: every legal combination clears it
  a_r7_err_clear: assert property (@(posedge bclk_i)
    disable iff (!bclk_rst_ni) (sync_mode_i != 2'd1 || bus_presc_i == 4'd0) |=> !cfg_err_o);

endmodule

bind adc_clk_prescaler adc_clk_prescaler_chk #(.HALF_W(adc_clk_pkg::RATIO_W - 1)) u_chk (
  .kclk_i     (kclk_i),
  .kclk_rst_ni(kclk_rst_ni),
  .bclk_i     (bclk_i),
  .bclk_rst_ni(bclk_rst_ni),
  .sync_mode_i(sync_mode_i),
  .bus_presc_i(bus_presc_i),
  .cfg_err_o  (cfg_err_o),
  .en_k       (en_k),
  .en_b       (en_b),
  .bnd_k      (bnd_k),
  .byp_k      (byp_k),
  .div_k      (div_k),
  .at_half_k  (at_half_k),
  .half_k     (half_k),
  .bnd_b      (bnd_b),
  .byp_b      (byp_b),
  .half_b     (half_b)
);

// File: tb/adc_clk_prescaler_tb_top.sv
`timescale 1ns/1ps
module adc_clk_prescaler_tb_top;

  localparam int KCLK_PERIOD = 10;
  localparam int BCLK_PERIOD = 14;
  localparam int SETTLE_NS   = 6000;
  localparam int WATCHDOG_NS = 1500000;

  logic       kclk = 1'b0;
  logic       bclk = 1'b0;
  logic       krst_n = 1'b0;
  logic       brst_n = 1'b0;
  logic [3:0] code = 4'd3;
  logic [1:0] mode = 2'd0;
  logic [3:0] presc = 4'd0;
  logic       adc_clk;
  logic       cfg_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    int    hi_a;
    int    hi_b;
    int    lo_a;
    int    lo_b;
    bit    lo_any;
    string tag;
  } period_t;

  period_t sb_q[$];

  always #(KCLK_PERIOD/2) kclk = ~kclk;
  initial begin
    #3;
    forever #(BCLK_PERIOD/2) bclk = ~bclk;
  end

  adc_clk_prescaler dut_i (
    .kclk_i      (kclk),
    .kclk_rst_ni (krst_n),
    .bclk_i      (bclk),
    .bclk_rst_ni (brst_n),
    .ratio_code_i(code),
    .sync_mode_i (mode),
    .bus_presc_i (presc),
    .adc_clk_o   (adc_clk),
    .cfg_err_o   (cfg_err)
  );

  // Ratio list restated as ranges of the code
  function automatic int exp_kratio(input int c);
    if (c < 3)  return 1 << c;
    if (c < 7)  return 2 * c;
    if (c < 12) return 16 << (c - 7);
    return 256;
  endfunction

  function automatic int exp_bratio(input int m);
    return 1 << (m - 1);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int ha, input int hb, input int la, input int lb,
                      input bit any, input string tag);
    period_t p;
    p.hi_a = ha; p.hi_b = hb; p.lo_a = la; p.lo_b = lb; p.lo_any = any; p.tag = tag;
    sb_q.push_back(p);
  endtask

  task automatic steady(input int half_ns, input int n, input string tag);
    for (int i = 0; i < n; i++) push(half_ns, half_ns, half_ns, half_ns, 1'b0, tag);
    wait (sb_q.size() == 0);
  endtask

  // Monitor: measures high and low phases and compares against the queue
  initial begin : monitor
    time t0, t1, t2;
    bit  primed;
    period_t p;
    int  hi, lo;
    bit  ok;
    primed = 1'b0;
    t2 = 0;
    forever begin
      wait (sb_q.size() != 0);
      if (primed) t0 = t2;
      else begin
        @(posedge adc_clk);
        t0 = $time;
      end
      @(negedge adc_clk);
      t1 = $time;
      @(posedge adc_clk);
      t2 = $time;
      p  = sb_q[0];
      hi = int'(t1 - t0);
      lo = int'(t2 - t1);
      ok = (hi == p.hi_a || hi == p.hi_b) &&
           (p.lo_any ? (lo > 0) : (lo == p.lo_a || lo == p.lo_b));
      checks++;
      if (!ok) begin
        fails++;
        $display("FAIL %s: actual hi=%0d lo=%0d expected hi=%0d|%0d lo=%0d|%0d%s",
                 p.tag, hi, lo, p.hi_a, p.hi_b, p.lo_a, p.lo_b,
                 p.lo_any ? " (lo any)" : "");
      end
      void'(sb_q.pop_front());
      primed = (sb_q.size() != 0);
    end
  end

  task automatic err_case(input int m, input int pr, input bit exp, input string tag);
    mode  = 2'(m);
    presc = 4'(pr);
    #(5 * BCLK_PERIOD);
    check(cfg_err == exp, tag, int'(cfg_err), int'(exp));
  endtask

  initial begin : watchdog
    #(WATCHDOG_NS);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    int half_o, half_n;
    // R1: reset state
    #41;
    check(adc_clk == 1'b0, "R1 clock low in reset", int'(adc_clk), 0);
    check(cfg_err == 1'b0, "R1 flag low in reset", int'(cfg_err), 0);
    #37;
    check(adc_clk == 1'b0, "R1 clock still low", int'(adc_clk), 0);
    krst_n = 1'b1;
    #9;
    brst_n = 1'b1;
    #(SETTLE_NS);

    // R2 / R4 / R5 / R3: sweep of every code on the kernel route
    for (int c = 0; c < 16; c++) begin
      code = 4'(c);
      #(SETTLE_NS);
      if (c == 0)       steady(KCLK_PERIOD / 2, 2, "R5 pass-through");
      else if (c >= 12) steady(exp_kratio(c) * KCLK_PERIOD / 2, 2, "R3 saturated code");
      else              steady(exp_kratio(c) * KCLK_PERIOD / 2, 2, "R2 R4 kernel ratio");
    end

    // R8: ratio changes within the kernel route
    code = 4'd2;
    #(SETTLE_NS);
    steady(2 * KCLK_PERIOD, 2, "R8 before step up");
    code = 4'd4;
    for (int i = 0; i < 6; i++) push(20, 40, 20, 40, 1'b0, "R8 step up 4->8");
    wait (sb_q.size() == 0);
    steady(40, 2, "R8 after step up");
    code = 4'd1;
    for (int i = 0; i < 8; i++) push(10, 40, 10, 40, 1'b0, "R8 step down 8->2");
    wait (sb_q.size() == 0);
    code = 4'd0;
    for (int i = 0; i < 8; i++) push(5, 10, 5, 10, 1'b0, "R8 into pass-through");
    wait (sb_q.size() == 0);
    code = 4'd6;
    for (int i = 0; i < 6; i++) push(5, 60, 5, 60, 1'b0, "R8 out of pass-through");
    wait (sb_q.size() == 0);
    steady(60, 2, "R8 settled at 12");

    // R6 and R9: bus route and route changes
    code = 4'd4;
    #(SETTLE_NS);
    mode = 2'd3;
    half_o = 40;
    half_n = exp_bratio(3) * BCLK_PERIOD / 2;
    for (int i = 0; i < 6; i++) push(half_o, half_n, 0, 0, 1'b1, "R9 kernel to bus");
    wait (sb_q.size() == 0);
    steady(half_n, 2, "R6 bus divide by 4");
    for (int m = 1; m <= 3; m++) begin
      mode = 2'(m);
      #(SETTLE_NS);
      steady(exp_bratio(m) * BCLK_PERIOD / 2, 2, "R6 bus ratio");
    end
    mode = 2'd2;
    #(SETTLE_NS);
    mode = 2'd0;
    for (int i = 0; i < 6; i++) push(BCLK_PERIOD, 40, 0, 0, 1'b1, "R9 bus to kernel");
    wait (sb_q.size() == 0);
    steady(40, 2, "R9 kernel after return");

    // R7: configuration error flag
    err_case(1, 3, 1'b1, "R7 undivided bus with divided bus clock");
    err_case(1, 0, 1'b0, "R7 undivided bus with undivided bus clock");
    err_case(2, 3, 1'b0, "R7 bus divide by 2");
    err_case(0, 5, 1'b0, "R7 kernel route");
    err_case(1, 1, 1'b1, "R7 flag raised again");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule